// File: doc/BRIEF.md
# Segment Identifier Scrambler

This block turns an effective segment number into a virtual segment identifier for the address translation path. It first builds a 36-bit intermediate identifier. In supervisor mode that identifier is the full 36-bit segment number. In user mode it is the 20-bit address-space context placed above the low 15 segment bits. The block then multiplies the intermediate identifier by the fixed prime 200730139 and reduces the product modulo 2^36-1. Because the multiplier is coprime to the modulus, the mapping is one-to-one, and it spreads neighbouring segments across a hashed page table.

The reduction uses no divider. The 64-bit product is split into its high and low parts, and the two parts are added end-around. A single conditional increment then brings the sum into range. The pipeline accepts one request per cycle and returns each result a fixed three cycles later. It also raises a flag when the intermediate identifier falls in a reserved range; the scrambled value is still produced in that case.

Top module: `seg_id_scrambler`

## Requirements
- R1: In user mode (`in_kernel`=0) the intermediate identifier is `{1'b0, in_ctx[19:0], in_esid[14:0]}`, so bits 35:15 of `in_esid` have no effect on the result.
- R2: In supervisor mode (`in_kernel`=1) the intermediate identifier is `in_esid[35:0]` unchanged, and `in_ctx` has no effect.
- R3: `out_vsid` equals (identifier × 200730139) mod (2^36−1), so it is never all ones.
- R4: A request accepted at a rising edge (`in_valid` and `in_ready` both high) yields `out_valid` high with its result after the third rising edge, counting the accepting edge. Back-to-back requests produce back-to-back results in order.
- R5: `out_rsvd` is high with a result whose identifier has bits 35:34 equal to binary 10, and `out_vsid` still carries the scrambled value.
- R6: `out_rsvd` is high with a result whose identifier is all ones (2^36−1), and `out_vsid` is then 0.
- R7: A user-mode result never has `out_rsvd` set, even with context and segment bits all ones.
- R8: While `rst_n` is low, `out_valid` and `in_ready` are 0 and `out_vsid` is 0. `in_ready` rises within three rising edges after `rst_n` is released.
- R9: A cycle with `in_valid` low produces a cycle with `out_valid` low three edges later, and `out_vsid` holds its previous value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block accepts a request this cycle (high whenever out of reset) |
| in_kernel | input | 1 | 1 = supervisor identifier, 0 = user identifier |
| in_ctx | input | 20 | User address-space context |
| in_esid | input | 36 | Effective segment number |
| out_valid | output | 1 | Result present |
| out_vsid | output | 36 | Scrambled segment identifier |
| out_rsvd | output | 1 | Intermediate identifier is in a reserved range |

## Verification
The bench compares every result against a direct 128-bit product and `%` reduction, so a wrong fold or correction shows up on the cases where the folded sum lands exactly on 2^36−1. The all-ones identifier is one such case; a design with no plus-one step would return all ones there instead of zero. The bench walks single bits through the context and the segment number, sets junk in the ignored upper segment bits in user mode, and places supervisor identifiers at the edges of the reserved 10 prefix. A mis-merged field or an inverted prefix test would therefore give a wrong result or a wrong flag. Gaps in the request stream expose a design that asserts valid on a stale stage or fails to hold its output.

// File: rtl/sid_scr_pkg.sv
package sid_scr_pkg;

  typedef enum logic {
    MODE_USER   = 1'b0,
    MODE_KERNEL = 1'b1
  } sid_mode_e;

endpackage

// File: rtl/sid_proto_form.sv
module sid_proto_form
  import sid_scr_pkg::*;
#(
  parameter int VSID_W  = 36,
  parameter int CTX_W   = 20,
  parameter int UESID_W = 15
) (
  input  sid_mode_e         mode,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [VSID_W-1:0] esid,
  output logic [VSID_W-1:0] proto,
  output logic              rsvd
);
  localparam int USER_W = CTX_W + UESID_W;
  localparam int PAD_W  = VSID_W - USER_W;

  logic [VSID_W-1:0] user_proto;

  generate
    if (PAD_W > 0) begin : g_pad
      assign user_proto = {{PAD_W{1'b0}}, ctx, esid[UESID_W-1:0]};
    end else begin : g_nopad
      assign user_proto = {ctx, esid[UESID_W-1:0]};
    end
  endgenerate

  always_comb begin
    proto = (mode == MODE_KERNEL) ? esid : user_proto;
    rsvd  = (proto[VSID_W-1:VSID_W-2] == 2'b10) || (&proto);
  end
endmodule

// File: rtl/sid_mult.sv
module sid_mult #(
  parameter int          VSID_W  = 36,
  parameter int          MULT_W  = 28,
  parameter logic [63:0] MULT    = 64'd200730139,
  parameter int          CHUNK_W = 7
) (
  input  logic [VSID_W-1:0]        a,
  output logic [VSID_W+MULT_W-1:0] prod
);
  localparam int PROD_W   = VSID_W + MULT_W;
  localparam int N_CHUNKS = (MULT_W + CHUNK_W - 1) / CHUNK_W;
  localparam int MPAD_W   = N_CHUNKS * CHUNK_W;
  localparam logic [MPAD_W-1:0] MULT_P = MPAD_W'(MULT);

  logic [PROD_W-1:0] pp [N_CHUNKS];

  genvar g;
  generate
    for (g = 0; g < N_CHUNKS; g++) begin : g_pp
      localparam logic [CHUNK_W-1:0] DIG = MULT_P[g*CHUNK_W +: CHUNK_W];
      logic [VSID_W+CHUNK_W-1:0] part;
      always_comb begin
        part  = (VSID_W+CHUNK_W)'(a) * (VSID_W+CHUNK_W)'(DIG);
        pp[g] = PROD_W'(part) << (g * CHUNK_W);
      end
    end
  endgenerate

  always_comb begin
    prod = '0;
    for (int i = 0; i < N_CHUNKS; i++) begin
      prod = prod + pp[i];
    end
  end
endmodule

// File: rtl/sid_mod_fold.sv
module sid_mod_fold #(
  parameter int VSID_W = 36,
  parameter int MULT_W = 28
) (
  input  logic [VSID_W+MULT_W-1:0] prod,
  output logic [VSID_W-1:0]        res
);
  localparam int SUM_W = VSID_W + 1;

  logic [SUM_W-1:0] hi, lo, fold, fold_inc, fixed;

  always_comb begin
    hi       = SUM_W'(prod[VSID_W+MULT_W-1:VSID_W]);
    lo       = SUM_W'(prod[VSID_W-1:0]);
    fold     = hi + lo;
    fold_inc = fold + SUM_W'(1);
    fixed    = fold + SUM_W'(fold_inc[VSID_W]);
    res      = fixed[VSID_W-1:0];
  end
endmodule

// File: rtl/seg_id_scrambler.sv
module seg_id_scrambler
  import sid_scr_pkg::*;
#(
  parameter int          VSID_W  = 36,
  parameter int          CTX_W   = 20,
  parameter int          UESID_W = 15,
  parameter int          MULT_W  = 28,
  parameter logic [63:0] MULT    = 64'd200730139,
  parameter int          CHUNK_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_kernel,
  input  logic [CTX_W-1:0]  in_ctx,
  input  logic [VSID_W-1:0] in_esid,
  output logic              out_valid,
  output logic [VSID_W-1:0] out_vsid,
  output logic              out_rsvd
);
  localparam int PROD_W = VSID_W + MULT_W;

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic              rdy_q;
  logic              v1_q, v2_q, v3_q;
  logic              r1_q, r2_q, r3_q;
  logic [VSID_W-1:0] proto_q, res_q;
  logic [PROD_W-1:0] prod_q;

  logic              accept;
  logic [VSID_W-1:0] proto_d, res_d;
  logic              rsvd_d;
  logic [PROD_W-1:0] prod_d;
  logic              v1_d, v2_d, v3_d;

  sid_proto_form #(
    .VSID_W (VSID_W),
    .CTX_W  (CTX_W),
    .UESID_W(UESID_W)
  ) u_form (
    .mode (sid_mode_e'(in_kernel)),
    .ctx  (in_ctx),
    .esid (in_esid),
    .proto(proto_d),
    .rsvd (rsvd_d)
  );

  sid_mult #(
    .VSID_W (VSID_W),
    .MULT_W (MULT_W),
    .MULT   (MULT),
    .CHUNK_W(CHUNK_W)
  ) u_mult (
    .a   (proto_q),
    .prod(prod_d)
  );

  sid_mod_fold #(
    .VSID_W(VSID_W),
    .MULT_W(MULT_W)
  ) u_fold (
    .prod(prod_q),
    .res (res_d)
  );

  always_comb begin
    accept = in_valid && rdy_q;
    v1_d   = accept;
    v2_d   = v1_q;
    v3_d   = v2_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdy_q <= 1'b0;
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      v3_q  <= 1'b0;
      r3_q  <= 1'b0;
      res_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      v1_q  <= v1_d;
      v2_q  <= v2_d;
      v3_q  <= v3_d;
      if (v2_q) begin
        r3_q  <= r2_q;
        res_q <= res_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      proto_q <= proto_d;
      r1_q    <= rsvd_d;
    end
    if (v1_q) begin
      prod_q <= prod_d;
      r2_q   <= r1_q;
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = v3_q;
  assign out_vsid  = res_q;
  assign out_rsvd  = r3_q;
endmodule

// File: rtl/seg_id_scrambler_chk.sv
module seg_id_scrambler_chk #(
  parameter int VSID_W = 36,
  parameter int CTX_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_kernel,
  input logic [CTX_W-1:0]  in_ctx,
  input logic [VSID_W-1:0] in_esid,
  input logic              out_valid,
  input logic [VSID_W-1:0] out_vsid,
  input logic              out_rsvd
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(acc, 3));

  a_r3_not_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vsid != {VSID_W{1'b1}}));

  a_r5_prefix_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_kernel && in_esid[VSID_W-1:VSID_W-2] == 2'b10) |-> ##3 (out_valid && out_rsvd));

  a_r6_all_ones_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_kernel && (&in_esid)) |-> ##3 (out_valid && out_rsvd && out_vsid == '0));

  a_r7_user_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_kernel) |-> ##3 !out_rsvd);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_vsid));

  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !in_ready));
endmodule

bind seg_id_scrambler seg_id_scrambler_chk #(
  .VSID_W(VSID_W),
  .CTX_W (CTX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_kernel(in_kernel),
  .in_ctx   (in_ctx),
  .in_esid  (in_esid),
  .out_valid(out_valid),
  .out_vsid (out_vsid),
  .out_rsvd (out_rsvd)
);

// File: tb/seg_id_scrambler_test.sv
`timescale 1ns/1ps
module seg_id_scrambler_test;
  localparam logic [127:0] MULT_C = 128'd200730139;
  localparam logic [127:0] MOD_C  = (128'd1 << 36) - 128'd1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_kernel;
  logic [19:0] in_ctx;
  logic [35:0] in_esid;
  logic        in_ready, out_valid, out_rsvd;
  logic [35:0] out_vsid;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  seg_id_scrambler uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kernel(in_kernel), .in_ctx(in_ctx), .in_esid(in_esid),
    .out_valid(out_valid), .out_vsid(out_vsid), .out_rsvd(out_rsvd)
  );

  // expected-result pipeline: slot 2 is due at the current negedge
  logic        ev [3];
  logic [35:0] ed [3];
  logic        er [3];
  string       et [3];

  function automatic logic [35:0] mk_proto(logic k, logic [19:0] c, logic [35:0] e);
    if (k) return e;
    return {1'b0, c, e[14:0]};
  endfunction

  function automatic logic [35:0] ref_vsid(logic [35:0] p);
    logic [127:0] w;
    w = ({92'd0, p} * MULT_C) % MOD_C;
    return w[35:0];
  endfunction

  task automatic report(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic k, logic [19:0] c, logic [35:0] e, string tag);
    logic [35:0] p;
    @(negedge clk);
    if (ev[2]) begin
      report(et[2], "valid", 64'(out_valid), 64'd1);
      report(et[2], "vsid",  64'(out_vsid), 64'(ed[2]));
      report(et[2], "rsvd",  64'(out_rsvd), 64'(er[2]));
    end else begin
      report("R9", "bubble valid", 64'(out_valid), 64'd0);
      report("R9", "bubble hold",  64'(out_vsid), 64'(ed[2]));
    end
    p = mk_proto(k, c, e);
    ev[2] = ev[1]; ed[2] = ed[1]; er[2] = er[1]; et[2] = et[1];
    ev[1] = ev[0]; ed[1] = ed[0]; er[1] = er[0]; et[1] = et[0];
    ev[0] = v;
    if (v) begin
      ed[0] = ref_vsid(p);
      er[0] = (p[35:34] == 2'b10) || (&p);
      et[0] = tag;
    end else begin
      ed[0] = ed[1]; // bubble: output expected to hold the most recent result
      er[0] = er[1];
      et[0] = "R9";
    end
    in_valid = v; in_kernel = k; in_ctx = c; in_esid = e;
  endtask

  // keep the hold expectation aligned with the last real result in flight
  task automatic fix_hold();
    if (!ev[0]) begin ed[0] = ed[1]; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; in_valid = 1'b0; in_kernel = 1'b0; in_ctx = '0; in_esid = '0;
    for (int i = 0; i < 3; i++) begin ev[i] = 1'b0; ed[i] = '0; er[i] = 1'b0; et[i] = "R9"; end
    repeat (3) @(negedge clk);
    report("R8", "reset valid", 64'(out_valid), 64'd0);
    report("R8", "reset ready", 64'(in_ready), 64'd0);
    report("R8", "reset vsid",  64'(out_vsid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    report("R8", "ready after release", 64'(in_ready), 64'd1);
    report("R8", "idle valid", 64'(out_valid), 64'd0);

    // supervisor corners (R2, R3, R5, R6)
    step(1, 1, 20'hABCDE, 36'h0,          "R2");
    step(1, 1, 20'h12345, 36'h1,          "R2");
    step(1, 1, 20'h0,     36'hF_FFFF_FFFF, "R6");
    step(1, 1, 20'h0,     36'h8_0000_0000, "R5");
    step(1, 1, 20'h0,     36'hB_FFFF_FFFF, "R5");
    step(1, 1, 20'h0,     36'hC_0000_0000, "R2");
    step(1, 1, 20'h0,     36'hF_FFFF_FFFE, "R3");
    step(1, 1, 20'h0,     36'h7_FFFF_FFFF, "R3");
    // user corners (R1, R7)
    step(1, 0, 20'hFFFFF, 36'hF_FFFF_FFFF, "R7");
    step(1, 0, 20'h00000, 36'hF_FFFF_8000, "R1");
    step(1, 0, 20'h80000, 36'h0_0000_7FFF, "R7");

    // walking ones over context and segment number, both modes (R1, R2, R3)
    for (int b = 0; b < 20; b++) begin
      for (int s = 0; s < 36; s++) begin
        step(1, 0, 20'(1) << b, (36'(1) << s) | 36'hA_5A50_0000, "R1");
        step(1, 1, 20'(1) << b, 36'(1) << s, "R2");
      end
    end

    // random stream with gaps (R3, R4, R9)
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 5) != 0;
      step(v, 1'($urandom), 20'($urandom), {4'($urandom), 32'($urandom)}, v ? "R4" : "R9");
      fix_hold();
    end

    // reserved-prefix sweep over low bits (R5)
    for (int i = 0; i < 64; i++) begin
      step(1, 1, 20'h0, {2'b10, 28'($urandom), 6'(i)}, "R5");
    end

    for (int i = 0; i < 4; i++) step(0, 0, 20'h0, 36'h0, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule